// File: doc/BRIEF.md
# Debug Port Control Register Bank

This block is the register bank behind a two-wire debug port. A protocol engine, outside this block, turns each serial request into a decoded access: a read/write flag, a port/access-port flag and a 2-bit register address. When the port flag marks the access as belonging to the debug port, the bank reads or updates its registers. One cycle later it returns a response beat carrying read data and an OK flag. Accesses aimed at an access port are left alone and produce no response.

The bank holds several registers:

- A fixed identification word.
- A control/status register. It carries the power-up and debug-reset request/acknowledge handshakes, the transaction count, the byte-lane mask and the transfer-mode field. It also holds the sticky error flags.
- A write-only abort register. It requests a port abort and clears the sticky flags one by one.
- A write-only select register. It picks the access port, its bank window and which register appears at address 0b01.
- A wire control register holding the turnaround length.

Event pulses from the protocol engine and the access-port side set the sticky flags. A sticky bus error blocks forwarding to the system bus. The three acknowledge inputs come from another clock domain, and each passes through a two-flop synchronizer.

The request side has no back-pressure. A request is taken in every cycle in which `req_valid` is high. The response beat (`rsp_valid` with `rsp_rdata`/`rsp_ok`) appears exactly one cycle later and cannot be stalled, so the engine must be ready to accept it.

Top module: `dbgport_regbank`

## Requirements
- R1: A read of address 0b00 returns 0x24D2A58B, whatever the value of CTRLSEL. This word is built as follows: version 0x2 in [31:28], part number 0x4D2A in [27:12], manufacturer code 0x2C5 in [11:1], and 1 in bit 0.
- R2: A write to address 0b10 loads the AP select from [31:24] (output `ap_sel`), the bank window from [7:4] (output `ap_bank`) and CTRLSEL from bit 0. All three reset to 0, and the other data bits are ignored.
- R3: Address 0b01 is banked by CTRLSEL. When CTRLSEL is 0, a read or write there reaches control/status. When CTRLSEL is 1, it reaches wire control instead, and control/status keeps its value.
- R4: Control/status has these writable fields, all resetting to 0: system power-up request bit 30, debug power-up request bit 28, debug reset request bit 26, transaction count [21:12], lane mask [11:8], transfer mode [3:2] and overrun-detect enable bit 0. The request bits drive `sys_pwrup_req`, `dbg_pwrup_req` and `dbg_rst_req`, and the mode and mask fields drive `trn_mode` and `mask_lane`. Bits [25:22] read as zero. Writes to the flag and acknowledge bits are ignored.
- R5: The acknowledges appear in control/status as follows: system at bit 31, debug power-up at bit 29, debug reset at bit 27. Each passes through two flops, so a change seen at clock edge k shows in a read accepted at edge k+2.
- R6: The sticky flags are set by event pulses and hold until cleared: bus error sets bit 5, compare match sets bit 4, write-data error sets bit 7. An overrun sets bit 1 only while the enable in bit 0 is 1.
- R7: An abort write (address 0b00) clears sticky flags by its data bits: bit 1 clears compare, bit 2 clears bus error, bit 3 clears write-data error and bit 4 clears overrun. Several flags may be cleared in one write. A setting event in the same cycle as a clear wins.
- R8: Abort data bit 0 gives a one-cycle `dap_abort` pulse, which coincides with the response beat. It also zeroes the transaction count and leaves every sticky flag unchanged.
- R9: Bit 6 takes the value of `ev_rd_ok` on each `ev_rd_done` pulse and holds otherwise.
- R10: `ap_fwd_block` is high exactly while the bus-error flag (bit 5) is set.
- R11: In wire control, turnaround [9:8] resets to 00 and is writable (value n means n+1 sample periods), and drives `turnround`. The mode field [7:6] always reads 01. All other bits read as zero.
- R12: Each debug-port request (`req_valid` high, `req_ap` low) yields `rsp_valid` one cycle later. `rsp_ok` is 1 for: the abort write, the identification read, address 0b01 reads and writes, and the select write. A read of 0b10 or 0b11, or a write of 0b11, answers with `rsp_ok`=0 and zero data and changes nothing. An access-port request gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Decoded access present this cycle |
| req_ap | input | 1 | 1 = access-port access (ignored here) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat, one cycle after request |
| rsp_rdata | output | 32 | Read data of the response |
| rsp_ok | output | 1 | Response is OK |
| ev_bus_err | input | 1 | System bus error pulse |
| ev_wdata_err | input | 1 | Write-data parity/framing error or dropped write |
| ev_overrun | input | 1 | Overrun pulse |
| ev_cmp_match | input | 1 | Pushed compare/verify match pulse |
| ev_rd_done | input | 1 | Access-port or read-buffer read finished |
| ev_rd_ok | input | 1 | That read answered OK |
| sys_pwrup_ack | input | 1 | System power-up acknowledge (asynchronous) |
| dbg_pwrup_ack | input | 1 | Debug power-up acknowledge (asynchronous) |
| dbg_rst_ack | input | 1 | Debug reset acknowledge (asynchronous) |
| sys_pwrup_req | output | 1 | System power-up request |
| dbg_pwrup_req | output | 1 | Debug power-up request |
| dbg_rst_req | output | 1 | Debug reset request |
| dap_abort | output | 1 | Port abort pulse |
| ap_sel | output | 8 | Selected access port |
| ap_bank | output | 4 | Selected register window |
| trn_mode | output | 2 | Transfer mode |
| mask_lane | output | 4 | Compare byte-lane mask |
| turnround | output | 2 | Turnaround length code |
| ap_fwd_block | output | 1 | Forwarding to system bus blocked |

## Verification
Two functions can fall in the same cycle: a sticky flag being set by its event pulse, and the same flag being cleared by an abort write. There is a second overlap as well: a port abort arriving while flags are set and a transaction count is loaded. The bench provokes both, with directed coincident pulses and with a long randomized stretch. In that stretch, events, abort writes with mixed clear bits and status reads land together freely. A behavioural model in the bench predicts every output on every clock, with set-wins and abort-keeps-flags as its rules, and each output is judged against that prediction.

// File: rtl/dbgport_pkg.sv
package dbgport_pkg;
  typedef enum logic [1:0] {
    ADR_IDABT = 2'd0,
    ADR_CTLWC = 2'd1,
    ADR_SEL   = 2'd2,
    ADR_NONE  = 2'd3
  } dp_addr_e;

  // abort data [4:0], MSB first
  typedef struct packed {
    logic orun;
    logic wderr;
    logic err;
    logic cmp;
    logic abort;
  } abort_t;

  typedef struct packed {
    logic wderr;
    logic readok;
    logic err;
    logic cmp;
    logic orun;
  } flags_t;

  localparam int CS_ACK_TOP  = 31;
  localparam int CS_REQ_TOP  = 30;
  localparam int CS_TRN_LSB  = 12;
  localparam int CS_MASK_LSB = 8;
  localparam int CS_WDE      = 7;
  localparam int CS_ROK      = 6;
  localparam int CS_ERR      = 5;
  localparam int CS_CMP      = 4;
  localparam int CS_MODE_LSB = 2;
  localparam int CS_ORUN     = 1;
  localparam int CS_ORDET    = 0;
  localparam int SEL_AP_LSB  = 24;
  localparam int SEL_BK_LSB  = 4;
  localparam int WC_TR_LSB   = 8;
  localparam int WC_MD_LSB   = 6;
endpackage

// File: rtl/dbgport_sync.sv
module dbgport_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] warm;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= '0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
      end
      // R5: output equals the input of two edges earlier
      p_sync_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (q == $past(d, 2)));
    end
  endgenerate
endmodule

// File: rtl/dbgport_flags.sv
module dbgport_flags
  import dbgport_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr_v,
  input  abort_t clr,
  input  logic   ev_bus_err,
  input  logic   ev_wdata_err,
  input  logic   ev_overrun,
  input  logic   ev_cmp_match,
  input  logic   orun_en,
  input  logic   rd_done,
  input  logic   rd_ok,
  output flags_t flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags.cmp   <= (flags.cmp   & ~(clr_v & clr.cmp))   | ev_cmp_match;
      flags.err   <= (flags.err   & ~(clr_v & clr.err))   | ev_bus_err;
      flags.wderr <= (flags.wderr & ~(clr_v & clr.wderr)) | ev_wdata_err;
      flags.orun  <= (flags.orun  & ~(clr_v & clr.orun))  | (ev_overrun & orun_en);
      if (rd_done) flags.readok <= rd_ok;
    end
  end

  p_abort_keeps_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v && clr.abort && !clr.err && flags.err) |=> flags.err);
  p_clear_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v && clr.err && !ev_bus_err) |=> !flags.err);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp_match |=> flags.cmp);
  p_orun_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!orun_en && !flags.orun) |=> !flags.orun);
endmodule

// File: rtl/dbgport_cfg.sv
module dbgport_cfg
  import dbgport_pkg::*;
#(
  parameter int TRN_W   = 10,
  parameter int MASK_W  = 4,
  parameter int APSEL_W = 8,
  parameter int BANK_W  = 4,
  parameter int NREQ    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_sel,
  input  logic               wr_ctrl,
  input  logic               wr_wcr,
  input  logic               abort_req,
  input  logic [31:0]        wdata,
  output logic [APSEL_W-1:0] apsel,
  output logic [BANK_W-1:0]  bank,
  output logic               ctrlsel,
  output logic [NREQ-1:0]    pwr_req,
  output logic [TRN_W-1:0]   trncnt,
  output logic [MASK_W-1:0]  mask,
  output logic [1:0]         trnmode,
  output logic               orun_en,
  output logic [1:0]         turnround
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      apsel   <= '0;
      bank    <= '0;
      ctrlsel <= 1'b0;
    end else if (wr_sel) begin
      apsel   <= wdata[SEL_AP_LSB +: APSEL_W];
      bank    <= wdata[SEL_BK_LSB +: BANK_W];
      ctrlsel <= wdata[0];
    end
  end

  generate
    for (genvar i = 0; i < NREQ; i++) begin : g_req
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pwr_req[i] <= 1'b0;
        else if (wr_ctrl) pwr_req[i] <= wdata[CS_REQ_TOP - 2*i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trncnt  <= '0;
      mask    <= '0;
      trnmode <= '0;
      orun_en <= 1'b0;
    end else if (abort_req) begin
      trncnt  <= '0;
    end else if (wr_ctrl) begin
      trncnt  <= wdata[CS_TRN_LSB +: TRN_W];
      mask    <= wdata[CS_MASK_LSB +: MASK_W];
      trnmode <= wdata[CS_MODE_LSB +: 2];
      orun_en <= wdata[CS_ORDET];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      turnround <= 2'b00;
    else if (wr_wcr) turnround <= wdata[WC_TR_LSB +: 2];
  end

  p_abort_zeroes_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (trncnt == '0));
  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(ctrlsel));
endmodule

// File: rtl/dbgport_regbank.sv
module dbgport_regbank
  import dbgport_pkg::*;
#(
  parameter int          APSEL_W = 8,
  parameter int          BANK_W  = 4,
  parameter int          TRN_W   = 10,
  parameter int          MASK_W  = 4,
  parameter int          SYNC_N  = 2,
  parameter logic [3:0]  ID_VER  = 4'h2,
  parameter logic [15:0] ID_PART = 16'h4D2A,
  parameter logic [10:0] ID_MFR  = 11'h2C5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_ap,
  input  logic               req_write,
  input  logic [1:0]         req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_ok,
  input  logic               ev_bus_err,
  input  logic               ev_wdata_err,
  input  logic               ev_overrun,
  input  logic               ev_cmp_match,
  input  logic               ev_rd_done,
  input  logic               ev_rd_ok,
  input  logic               sys_pwrup_ack,
  input  logic               dbg_pwrup_ack,
  input  logic               dbg_rst_ack,
  output logic               sys_pwrup_req,
  output logic               dbg_pwrup_req,
  output logic               dbg_rst_req,
  output logic               dap_abort,
  output logic [APSEL_W-1:0] ap_sel,
  output logic [BANK_W-1:0]  ap_bank,
  output logic [1:0]         trn_mode,
  output logic [MASK_W-1:0]  mask_lane,
  output logic [1:0]         turnround
  ,output logic              ap_fwd_block
);
  localparam int NHS = 3;
  localparam logic [31:0] ID_WORD = {ID_VER, ID_PART, ID_MFR, 1'b1};

  dp_addr_e addr;
  abort_t   ab;
  logic     dp, wr_abort, wr_ctrl, wr_wcr, wr_sel, rd_id, rd_bank, hit;
  logic     ctrlsel, orun_en;
  logic [NHS-1:0]    acks, acks_s, reqs;
  logic [TRN_W-1:0]  trncnt;
  flags_t   flags;
  logic [31:0] cs_word, wc_word, rd_mux;

  assign addr     = dp_addr_e'(req_addr);
  assign ab       = abort_t'(req_wdata[4:0]);
  assign dp       = req_valid & ~req_ap;
  assign wr_abort = dp & req_write & (addr == ADR_IDABT);
  assign wr_ctrl  = dp & req_write & (addr == ADR_CTLWC) & ~ctrlsel;
  assign wr_wcr   = dp & req_write & (addr == ADR_CTLWC) & ctrlsel;
  assign wr_sel   = dp & req_write & (addr == ADR_SEL);
  assign rd_id    = dp & ~req_write & (addr == ADR_IDABT);
  assign rd_bank  = dp & ~req_write & (addr == ADR_CTLWC);
  assign hit      = wr_abort | wr_ctrl | wr_wcr | wr_sel | rd_id | rd_bank;

  assign acks = {dbg_rst_ack, dbg_pwrup_ack, sys_pwrup_ack};

  dbgport_sync #(.W(NHS), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(acks), .q(acks_s)
  );

  dbgport_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clr_v(wr_abort), .clr(ab),
    .ev_bus_err(ev_bus_err), .ev_wdata_err(ev_wdata_err),
    .ev_overrun(ev_overrun), .ev_cmp_match(ev_cmp_match),
    .orun_en(orun_en), .rd_done(ev_rd_done), .rd_ok(ev_rd_ok),
    .flags(flags)
  );

  dbgport_cfg #(
    .TRN_W(TRN_W), .MASK_W(MASK_W), .APSEL_W(APSEL_W),
    .BANK_W(BANK_W), .NREQ(NHS)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_ctrl(wr_ctrl),
    .wr_wcr(wr_wcr), .abort_req(wr_abort & ab.abort), .wdata(req_wdata),
    .apsel(ap_sel), .bank(ap_bank), .ctrlsel(ctrlsel), .pwr_req(reqs),
    .trncnt(trncnt), .mask(mask_lane), .trnmode(trn_mode),
    .orun_en(orun_en), .turnround(turnround)
  );

  always_comb begin
    cs_word = '0;
    for (int i = 0; i < NHS; i++) begin
      cs_word[CS_ACK_TOP - 2*i] = acks_s[i];
      cs_word[CS_REQ_TOP - 2*i] = reqs[i];
    end
    cs_word[CS_TRN_LSB +: TRN_W]   = trncnt;
    cs_word[CS_MASK_LSB +: MASK_W] = mask_lane;
    cs_word[CS_WDE]                = flags.wderr;
    cs_word[CS_ROK]                = flags.readok;
    cs_word[CS_ERR]                = flags.err;
    cs_word[CS_CMP]                = flags.cmp;
    cs_word[CS_MODE_LSB +: 2]      = trn_mode;
    cs_word[CS_ORUN]               = flags.orun;
    cs_word[CS_ORDET]              = orun_en;
  end

  always_comb begin
    wc_word = '0;
    wc_word[WC_TR_LSB +: 2] = turnround;
    wc_word[WC_MD_LSB +: 2] = 2'b01;
  end

  always_comb begin
    rd_mux = '0;
    if (rd_id)        rd_mux = ID_WORD;
    else if (rd_bank) rd_mux = ctrlsel ? wc_word : cs_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_rdata <= '0;
      dap_abort <= 1'b0;
    end else begin
      rsp_valid <= dp;
      rsp_ok    <= hit;
      rsp_rdata <= rd_mux;
      dap_abort <= wr_abort & ab.abort;
    end
  end

  assign sys_pwrup_req = reqs[0];
  assign dbg_pwrup_req = reqs[1];
  assign dbg_rst_req   = reqs[2];
  assign ap_fwd_block  = flags.err;

  p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ap) |=> rsp_valid);
  p_no_rsp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_ap) |=> !rsp_valid);
  p_block_rises_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err |=> ap_fwd_block);
endmodule

// File: tb/dbgport_regbank_test.sv
module dbgport_regbank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_ap = 0, req_write = 0;
  logic [1:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic ev_bus_err = 0, ev_wdata_err = 0, ev_overrun = 0, ev_cmp_match = 0;
  logic ev_rd_done = 0, ev_rd_ok = 0;
  logic sys_pwrup_ack = 0, dbg_pwrup_ack = 0, dbg_rst_ack = 0;
  logic rsp_valid, rsp_ok, sys_pwrup_req, dbg_pwrup_req, dbg_rst_req;
  logic dap_abort, ap_fwd_block;
  logic [31:0] rsp_rdata;
  logic [7:0] ap_sel;
  logic [3:0] ap_bank, mask_lane;
  logic [1:0] trn_mode, turnround;

  always #5 clk = ~clk;

  dbgport_regbank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ap(req_ap),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok),
    .ev_bus_err(ev_bus_err), .ev_wdata_err(ev_wdata_err),
    .ev_overrun(ev_overrun), .ev_cmp_match(ev_cmp_match),
    .ev_rd_done(ev_rd_done), .ev_rd_ok(ev_rd_ok),
    .sys_pwrup_ack(sys_pwrup_ack), .dbg_pwrup_ack(dbg_pwrup_ack),
    .dbg_rst_ack(dbg_rst_ack), .sys_pwrup_req(sys_pwrup_req),
    .dbg_pwrup_req(dbg_pwrup_req), .dbg_rst_req(dbg_rst_req),
    .dap_abort(dap_abort), .ap_sel(ap_sel), .ap_bank(ap_bank),
    .trn_mode(trn_mode), .mask_lane(mask_lane), .turnround(turnround),
    .ap_fwd_block(ap_fwd_block)
  );

  localparam logic [31:0] ID_EXP = 32'h24D2A58B;

  // reference model state
  bit m_rv, m_ok, m_dab, m_ctrlsel, m_orund, m_cmp, m_err, m_wde, m_orn, m_rok;
  bit [31:0] m_rd;
  bit [7:0]  m_apsel;
  bit [3:0]  m_bank, m_mask;
  bit [2:0]  m_req, m_s1, m_s2;
  bit [9:0]  m_trn;
  bit [1:0]  m_mode, m_tr;
  bit        dp, hit, ab;
  bit [31:0] rdv;

  int n_chk = 0, n_bad = 0;
  bit cmp_en = 0;
  bit done = 0;
  string tag = "R12";

  function automatic bit [31:0] cs_word();
    bit [31:0] w = '0;
    w[31] = m_s2[0]; w[30] = m_req[0];
    w[29] = m_s2[1]; w[28] = m_req[1];
    w[27] = m_s2[2]; w[26] = m_req[2];
    w[21:12] = m_trn; w[11:8] = m_mask;
    w[7] = m_wde; w[6] = m_rok; w[5] = m_err; w[4] = m_cmp;
    w[3:2] = m_mode; w[1] = m_orn; w[0] = m_orund;
    return w;
  endfunction

  function automatic bit [31:0] wc_word();
    return {22'd0, m_tr, 2'b01, 6'd0};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rv = 0; m_ok = 0; m_rd = 0; m_dab = 0; m_ctrlsel = 0; m_apsel = 0;
      m_bank = 0; m_req = 0; m_trn = 0; m_mask = 0; m_mode = 0; m_orund = 0;
      m_cmp = 0; m_err = 0; m_wde = 0; m_orn = 0; m_rok = 0; m_tr = 0;
      m_s1 = 0; m_s2 = 0;
    end else begin
      dp = req_valid && !req_ap;
      hit = 0; rdv = 0;
      if (dp) begin
        if (req_write) hit = (req_addr != 2'd3);
        else if (req_addr == 2'd0) begin hit = 1; rdv = ID_EXP; end
        else if (req_addr == 2'd1) begin hit = 1; rdv = m_ctrlsel ? wc_word() : cs_word(); end
      end
      ab = dp && req_write && req_addr == 2'd0;
      m_cmp = (m_cmp && !(ab && req_wdata[1])) || ev_cmp_match;
      m_err = (m_err && !(ab && req_wdata[2])) || ev_bus_err;
      m_wde = (m_wde && !(ab && req_wdata[3])) || ev_wdata_err;
      m_orn = (m_orn && !(ab && req_wdata[4])) || (ev_overrun && m_orund);
      if (ev_rd_done) m_rok = ev_rd_ok;
      m_s2 = m_s1;
      m_s1 = {dbg_rst_ack, dbg_pwrup_ack, sys_pwrup_ack};
      if (ab && req_wdata[0]) m_trn = 0;
      else if (dp && req_write && req_addr == 2'd1 && !m_ctrlsel) begin
        m_req = {req_wdata[26], req_wdata[28], req_wdata[30]};
        m_trn = req_wdata[21:12]; m_mask = req_wdata[11:8];
        m_mode = req_wdata[3:2]; m_orund = req_wdata[0];
      end
      if (dp && req_write && req_addr == 2'd1 && m_ctrlsel) m_tr = req_wdata[9:8];
      if (dp && req_write && req_addr == 2'd2) begin
        m_apsel = req_wdata[31:24]; m_bank = req_wdata[7:4]; m_ctrlsel = req_wdata[0];
      end
      m_rv = dp; m_ok = hit; m_rd = rdv; m_dab = ab && req_wdata[0];
    end
  end

  task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R12", "rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) begin
        chk("R12", "rsp_ok", 32'(rsp_ok), 32'(m_ok));
        chk(tag, "rsp_rdata", rsp_rdata, m_rd);
      end
      chk("R8", "dap_abort", 32'(dap_abort), 32'(m_dab));
      chk("R4", "pwr reqs", 32'({dbg_rst_req, dbg_pwrup_req, sys_pwrup_req}), 32'(m_req));
      chk("R4", "mode/mask", 32'({trn_mode, mask_lane}), 32'({m_mode, m_mask}));
      chk("R2", "ap_sel/bank", 32'({ap_sel, ap_bank}), 32'({m_apsel, m_bank}));
      chk("R11", "turnround", 32'(turnround), 32'(m_tr));
      chk("R10", "fwd_block", 32'(ap_fwd_block), 32'(m_err));
    end
  end

  task automatic tick();
    @(negedge clk); #1;
    req_valid = 0; req_ap = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    ev_bus_err = 0; ev_wdata_err = 0; ev_overrun = 0; ev_cmp_match = 0;
    ev_rd_done = 0; ev_rd_ok = 0;
  endtask

  task automatic acc(input bit wr, input bit [1:0] a, input bit [31:0] d);
    req_valid = 1; req_ap = 0; req_write = wr; req_addr = a; req_wdata = d;
    tick();
  endtask

  task automatic rd_status();
    acc(0, 2'd1, 0);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    cmp_en = 1;
    tick(); tick();

    // R12 reset state
    tag = "R12";
    chk("R12", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R4", "reset reqs", 32'({dbg_rst_req, dbg_pwrup_req, sys_pwrup_req}), 32'd0);

    tag = "R1"; acc(0, 2'd0, 0); tick();

    tag = "R4";
    rd_status();
    acc(1, 2'd1, 32'hFFEA_B0FD);
    rd_status();
    acc(1, 2'd1, 32'h5004_5A09);
    rd_status();

    tag = "R5";
    sys_pwrup_ack = 1; tick();
    for (int i = 0; i < 4; i++) acc(0, 2'd1, 0);
    dbg_pwrup_ack = 1; dbg_rst_ack = 1; tick();
    for (int i = 0; i < 4; i++) acc(0, 2'd1, 0);
    sys_pwrup_ack = 0; tick(); tick(); tick();

    tag = "R6";
    ev_bus_err = 1; tick();
    ev_cmp_match = 1; tick();
    ev_wdata_err = 1; tick();
    ev_overrun = 1; tick();
    rd_status();
    acc(1, 2'd0, 32'h10);
    acc(1, 2'd1, 32'h0000_1000);
    ev_overrun = 1; tick();
    rd_status();

    tag = "R7";
    acc(1, 2'd0, 32'h2);
    rd_status();
    ev_cmp_match = 1; ev_overrun = 1; tick();
    ev_cmp_match = 1; acc(1, 2'd0, 32'h6);
    rd_status();
    acc(1, 2'd0, 32'h1E);
    rd_status();

    tag = "R8";
    ev_bus_err = 1; ev_cmp_match = 1; ev_wdata_err = 1; tick();
    acc(1, 2'd1, 32'h003F_F001);
    ev_overrun = 1; tick();
    acc(1, 2'd0, 32'h1);
    rd_status();

    tag = "R9";
    ev_rd_done = 1; ev_rd_ok = 1; tick();
    rd_status();
    ev_rd_ok = 1; tick();
    ev_rd_done = 1; ev_rd_ok = 0; tick();
    rd_status();

    tag = "R2";
    acc(1, 2'd2, 32'hA5FF_FF3E);
    tick();
    tag = "R3";
    acc(1, 2'd2, 32'h3C00_0051);
    acc(0, 2'd1, 0); tick();
    tag = "R11";
    acc(1, 2'd1, 32'hFFFF_FF3F);
    acc(0, 2'd1, 0); tick();
    tag = "R1"; acc(0, 2'd0, 0); tick();
    tag = "R3";
    acc(1, 2'd2, 32'h0);
    rd_status();

    tag = "R12";
    acc(0, 2'd2, 0); acc(0, 2'd3, 0);
    acc(1, 2'd3, 32'hFFFF_FFFF);
    req_valid = 1; req_ap = 1; req_write = 1; req_addr = 2'd2; req_wdata = 32'hFFFF_FFFF; tick();
    rd_status();

    tag = "R7";
    for (int i = 0; i < 3000; i++) begin
      ev_bus_err   = ($urandom % 8) == 0;
      ev_cmp_match = ($urandom % 6) == 0;
      ev_wdata_err = ($urandom % 7) == 0;
      ev_overrun   = ($urandom % 5) == 0;
      ev_rd_done   = ($urandom % 4) == 0;
      ev_rd_ok     = $urandom % 2;
      if (($urandom % 40) == 0) sys_pwrup_ack = ~sys_pwrup_ack;
      if (($urandom % 50) == 0) dbg_rst_ack = ~dbg_rst_ack;
      req_valid = ($urandom % 3) != 0;
      req_ap    = ($urandom % 6) == 0;
      req_write = $urandom % 2;
      req_addr  = ($urandom % 3 == 0) ? 2'd1 : 2'($urandom);
      req_wdata = $urandom;
      tick();
    end
    tick(); tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule